// File: doc/BRIEF.md
# Pipelined AES-128 Block Encryptor

This block encrypts a stream of 128-bit blocks under AES-128 and accepts a new block on every clock. All ten cipher rounds are unrolled, and each round is a two-register pipeline stage. The whole datapath has sixteen byte lanes, and each lane has its own registered substitution lookup. A ciphertext block leaves the block exactly twenty clocks after its plaintext entered. Gaps in the input stream appear unchanged in the output stream.

The eleven round keys are computed outside the block. They are written one at a time into a key register bank through a load port. Software reloads the bank between streams, while no block is in flight. The row rotation before column mixing costs no gates, because it is pure wire routing. Column mixing and key addition are merged, so each output byte comes from a single six-input XOR. The last round drops the column mixing and XORs the rotated substitution outputs straight with the final round key.

Top module: `aes128_enc_pipe`

## Requirements
- R1: While reset is asserted, and on every cycle after its release until new blocks have passed through, `out_valid` is 0. Reset clears only the valid chain. Stored round keys keep their values through reset.
- R2: `out_valid` equals `in_valid` delayed by exactly 20 clock cycles, including gaps. `out_data` carries the ciphertext of the block that was presented 20 cycles earlier.
- R3: With cipher key 000102030405060708090a0b0c0d0e0f expanded into the bank, plaintext 00112233445566778899aabbccddeeff encrypts to 69c4e0d86a7b0430d8cdb78070b4c55a.
- R4: Blocks presented on consecutive cycles are all encrypted correctly. The output is then valid on consecutive cycles in the same order.
- R5: Before round 1, the plaintext is XORed with round key 0 (bank slot 0).
- R6: Doubling in GF(2^8) shifts the byte left by one bit. When the bit shifted out is 1, the result is XORed with 0x1B. In rounds 1 to 9, each output byte is 2·a ^ 3·b ^ c ^ d ^ key byte, with the row rotation giving row r a left rotation by r columns.
- R7: Round 10 applies substitution, row rotation and round key 10, with no column mixing.
- R8: Setting `key_load` with `key_sel` = k, for k in 0..10, writes `key_data` into round-key slot k on that clock edge. A block presented after the write completes is encrypted with the new key.
- R9: A load with `key_sel` in 11..15 changes no stored key. The ciphertext of the following blocks is the same as without that load.
- R10: Byte 15 of a block is bits [127:120] and byte 0 is bits [7:0], for plaintext, ciphertext and keys alike. The first byte of the standard byte sequence sits in bits [127:120].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the valid chain |
| in_valid | input | 1 | Plaintext block present this cycle |
| in_data | input | 128 | Plaintext block, byte 15 in the top bits |
| key_load | input | 1 | Write `key_data` into the round-key slot selected by `key_sel` |
| key_sel | input | 4 | Round-key slot index, 0 to 10; larger values are ignored |
| key_data | input | 128 | Round key to store |
| out_valid | output | 1 | Ciphertext block present this cycle |
| out_data | output | 128 | Ciphertext block, byte 15 in the top bits |

## Verification
The known answers under two different key sets expose a wrong row rotation, a wrong lane order or a byte-reversed word: any of these scrambles all sixteen bytes. All-zero and all-ones blocks force the doubling reduction and the bare key addition. A missing 0x1B fold or a skipped round-0 key would corrupt them. Gapped and back-to-back streams are compared against a cycle-stamped scoreboard, so a stage with one register too many or too few shows up as a one-cycle slip. A reset in mid-stream shows whether stale blocks leak out. Writes to the unused slot indices would corrupt later ciphertext if the slot decode wrapped around.

// File: rtl/aes_pipe_pkg.sv
package aes_pipe_pkg;

  localparam int AES_ROUNDS = 10;
  localparam int BLK_W      = 128;
  localparam int BYTE_W     = 8;
  localparam int N_LANES    = BLK_W / BYTE_W;
  localparam int N_ROWS     = 4;
  localparam int N_COLS     = N_LANES / N_ROWS;
  localparam int N_RKEYS    = AES_ROUNDS + 1;
  localparam int PIPE_LAT   = 2 * AES_ROUNDS;
  localparam int KSEL_W     = $clog2(N_RKEYS);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [BLK_W-1:0]  blk_t;

  // doubling in GF(2^8) with the 0x1B fold
  function automatic byte_t gf_xtime(byte_t b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t acc = '0;
    byte_t x   = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ x;
      x = gf_xtime(x);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (0 maps to 0)
  function automatic byte_t gf_inv(byte_t a);
    byte_t r = 8'h01;
    byte_t p = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (((254 >> i) & 1) == 1) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic byte_t sbox_fwd(byte_t x);
    byte_t v = gf_inv(x);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  // one output byte of a mixing round: six XOR inputs, key folded in
  function automatic byte_t mix_xor6(byte_t a, byte_t b, byte_t c, byte_t d, byte_t k);
    return gf_xtime(a) ^ gf_xtime(b) ^ b ^ c ^ d ^ k;
  endfunction

endpackage

// File: rtl/aes_sbox_rom.sv
module aes_sbox_rom
  import aes_pipe_pkg::*;
(
  input  logic  clk,
  input  byte_t addr,
  output byte_t data
);

  // registered lookup: the table is a constant function of the address
  always_ff @(posedge clk) begin
    data <= sbox_fwd(addr);
  end

endmodule

// File: rtl/aes_rkey_bank.sv
module aes_rkey_bank
  import aes_pipe_pkg::*;
(
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [KSEL_W-1:0]        wr_sel,
  input  blk_t                     wr_data,
  output logic [N_RKEYS*BLK_W-1:0] keys_flat
);

  for (genvar gk = 0; gk < N_RKEYS; gk++) begin : g_slot
    blk_t slot_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_sel == KSEL_W'(gk))) slot_q <= wr_data;
    end
    assign keys_flat[gk*BLK_W +: BLK_W] = slot_q;
  end

endmodule

// File: rtl/aes_round_stage.sv
module aes_round_stage
  import aes_pipe_pkg::*;
#(
  parameter bit LAST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld_i,
  input  blk_t blk_i,
  input  blk_t rkey_i,
  output logic vld_mid_o,
  output logic vld_o,
  output blk_t blk_o
);

  byte_t sb_q [N_LANES];
  byte_t sh   [N_LANES];
  byte_t nx   [N_LANES];
  blk_t  nx_blk;

  // cycle 1: one registered substitution per lane
  for (genvar gl = 0; gl < N_LANES; gl++) begin : g_lane
    aes_sbox_rom u_rom (
      .clk  (clk),
      .addr (blk_i[BLK_W-1-BYTE_W*gl -: BYTE_W]),
      .data (sb_q[gl])
    );
  end

  // row rotation as wiring: row r of column c takes column (c+r) mod 4
  for (genvar gs = 0; gs < N_LANES; gs++) begin : g_shift
    localparam int ROW = gs % N_ROWS;
    localparam int COL = gs / N_ROWS;
    localparam int SRC = ROW + N_ROWS * ((COL + ROW) % N_COLS);
    assign sh[gs] = sb_q[SRC];
  end

  // cycle 2: mixing merged with key addition, or key addition alone
  for (genvar gc = 0; gc < N_COLS; gc++) begin : g_col
    for (genvar gr = 0; gr < N_ROWS; gr++) begin : g_row
      localparam int I = N_ROWS * gc + gr;
      byte_t kb;
      assign kb = rkey_i[BLK_W-1-BYTE_W*I -: BYTE_W];
      if (LAST) begin : g_final
        assign nx[I] = sh[I] ^ kb;
      end else begin : g_mix
        assign nx[I] = mix_xor6(sh[N_ROWS*gc + gr],
                                sh[N_ROWS*gc + (gr+1) % N_ROWS],
                                sh[N_ROWS*gc + (gr+2) % N_ROWS],
                                sh[N_ROWS*gc + (gr+3) % N_ROWS],
                                kb);
      end
    end
  end

  for (genvar gp = 0; gp < N_LANES; gp++) begin : g_pack
    assign nx_blk[BLK_W-1-BYTE_W*gp -: BYTE_W] = nx[gp];
  end

  always_ff @(posedge clk) begin
    blk_o <= nx_blk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_mid_o <= 1'b0;
      vld_o     <= 1'b0;
    end else begin
      vld_mid_o <= vld_i;
      vld_o     <= vld_mid_o;
    end
  end

endmodule

// File: rtl/aes128_enc_pipe.sv
module aes128_enc_pipe
  import aes_pipe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BLK_W-1:0]  in_data,
  input  logic              key_load,
  input  logic [KSEL_W-1:0] key_sel,
  input  logic [BLK_W-1:0]  key_data,
  output logic              out_valid,
  output logic [BLK_W-1:0]  out_data
);

  logic [N_RKEYS*BLK_W-1:0] rk_flat;
  logic [PIPE_LAT-1:0]      pipe_valid;
  blk_t                     stage_blk [AES_ROUNDS+1];
  logic                     stage_vld [AES_ROUNDS+1];

  aes_rkey_bank u_keys (
    .clk       (clk),
    .wr_en     (key_load),
    .wr_sel    (key_sel),
    .wr_data   (key_data),
    .keys_flat (rk_flat)
  );

  // round-0 key addition feeds the first lookup registers directly
  assign stage_blk[0] = in_data ^ rk_flat[0 +: BLK_W];
  assign stage_vld[0] = in_valid;

  for (genvar gr = 1; gr <= AES_ROUNDS; gr++) begin : g_round
    aes_round_stage #(.LAST(gr == AES_ROUNDS)) u_rnd (
      .clk       (clk),
      .rst_n     (rst_n),
      .vld_i     (stage_vld[gr-1]),
      .blk_i     (stage_blk[gr-1]),
      .rkey_i    (rk_flat[gr*BLK_W +: BLK_W]),
      .vld_mid_o (pipe_valid[2*gr-2]),
      .vld_o     (stage_vld[gr]),
      .blk_o     (stage_blk[gr])
    );
    assign pipe_valid[2*gr-1] = stage_vld[gr];
  end

  assign out_valid = stage_vld[AES_ROUNDS];
  assign out_data  = stage_blk[AES_ROUNDS];

endmodule

// File: rtl/aes128_enc_pipe_chk.sv
module aes128_enc_pipe_chk
  import aes_pipe_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     out_valid,
  input logic                     key_load,
  input logic [KSEL_W-1:0]        key_sel,
  input logic [BLK_W-1:0]         key_data,
  input logic [PIPE_LAT-1:0]      pipe_valid,
  input logic [N_RKEYS*BLK_W-1:0] rk_flat
);

  logic [PIPE_LAT-1:0] shad_q;

  always_ff @(posedge clk) begin
    if (!rst_n) shad_q <= '0;
    else        shad_q <= {shad_q[PIPE_LAT-2:0], in_valid};
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!out_valid && (pipe_valid == '0)));

  // R2
  lat_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == shad_q[PIPE_LAT-1]);

  // R2
  stage_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pipe_valid[PIPE_LAT-1:1] == $past(pipe_valid[PIPE_LAT-2:0])));

  // R8
  key_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_load && (key_sel < KSEL_W'(N_RKEYS)))
      |=> (rk_flat[$past(key_sel)*BLK_W +: BLK_W] == $past(key_data)));

  // R9
  key_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_load && (key_sel >= KSEL_W'(N_RKEYS))) |=> $stable(rk_flat));

endmodule

bind aes128_enc_pipe aes128_enc_pipe_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .key_load   (key_load),
  .key_sel    (key_sel),
  .key_data   (key_data),
  .pipe_valid (pipe_valid),
  .rk_flat    (rk_flat)
);

// File: tb/test_aes128_enc_pipe.sv
module test_aes128_enc_pipe;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_data;
  logic         key_load;
  logic [3:0]   key_sel;
  logic [127:0] key_data;
  logic         out_valid;
  logic [127:0] out_data;

  always #5 clk = ~clk;

  aes128_enc_pipe i_aes128_enc_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .key_load  (key_load),
    .key_sel   (key_sel),
    .key_data  (key_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  typedef struct {
    logic [127:0] d;
    longint       c;
    string        tag;
  } exp_t;

  exp_t         q[$];
  int           n_chk  = 0;
  int           n_fail = 0;
  longint       cyc    = 0;
  bit           mon_on = 1'b0;
  string        idle_tag = "R1";
  logic [7:0]   sb [256];
  logic [127:0] rk [11];
  logic [127:0] seed = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // ---------------- reference model ----------------
  function automatic logic [7:0] dbl(logic [7:0] b);
    return (b << 1) ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] rotl8(logic [7:0] v, int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic build_sbox();
    logic [7:0] p = 8'h01;
    logic [7:0] qv = 8'h01;
    do begin
      p  = p ^ dbl(p);
      qv = qv ^ (qv << 1);
      qv = qv ^ (qv << 2);
      qv = qv ^ (qv << 4);
      if (qv[7]) qv = qv ^ 8'h09;
      sb[p] = qv ^ rotl8(qv, 1) ^ rotl8(qv, 2) ^ rotl8(qv, 3) ^ rotl8(qv, 4) ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  task automatic expand(logic [127:0] ck);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = ck[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]};
        t[31:24] = t[31:24] ^ rc;
        rc = dbl(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] ref_enc(logic [127:0] pt);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] a0, a1, a2, a3;
    logic [127:0] res;
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ rk[0][127-8*i -: 8];
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) t[i] = sb[s[i]];
      for (int row = 0; row < 4; row++)
        for (int col = 0; col < 4; col++)
          s[row + 4*col] = t[row + 4*((col + row) % 4)];
      if (r < 10) begin
        for (int c = 0; c < 4; c++) begin
          a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
          s[4*c]   = dbl(a0) ^ dbl(a1) ^ a1 ^ a2 ^ a3;
          s[4*c+1] = a0 ^ dbl(a1) ^ dbl(a2) ^ a2 ^ a3;
          s[4*c+2] = a0 ^ a1 ^ dbl(a2) ^ dbl(a3) ^ a3;
          s[4*c+3] = dbl(a0) ^ a0 ^ a1 ^ a2 ^ dbl(a3);
        end
      end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ rk[r][127-8*i -: 8];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  function automatic logic [127:0] next_pt();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  // ---------------- driver ----------------
  task automatic send(logic [127:0] pt, logic [127:0] expv, string tag);
    in_valid = 1'b1;
    in_data  = pt;
    q.push_back('{expv, cyc + 20, tag});
    @(negedge clk);
  endtask

  task automatic gap(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic write_key(int sel, logic [127:0] d);
    key_load = 1'b1;
    key_sel  = 4'(sel);
    key_data = d;
    @(negedge clk);
    key_load = 1'b0;
  endtask

  task automatic load_keys(logic [127:0] ck);
    expand(ck);
    for (int r = 0; r < 11; r++) write_key(r, rk[r]);
  endtask

  task automatic drain();
    in_valid = 1'b0;
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (mon_on && rst_n === 1'b1) begin
      if (q.size() > 0 && q[0].c == cyc) begin
        exp_t e;
        e = q.pop_front();
        check(out_valid === 1'b1 && out_data === e.d, e.tag,
              out_valid === 1'b1 ? out_data : 128'(out_valid), e.d);
      end else begin
        check(out_valid === 1'b0, {idle_tag, " out_valid idle"},
              128'(out_valid), 128'd0);
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (R2 stream stalled) actual=hung expected=done");
    finish_test();
  end

  // ---------------- main flow ----------------
  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    key_load = 1'b0;
    key_sel  = '0;
    key_data = '0;
    build_sbox();
    repeat (4) @(negedge clk);
    rst_n    = 1'b1;
    idle_tag = "R1";
    mon_on   = 1'b1;
    repeat (22) @(negedge clk);            // R1: nothing leaves after reset

    // R8: load expanded key set 1
    load_keys(128'h000102030405060708090a0b0c0d0e0f);
    idle_tag = "R2";

    // R3 R10: known answer, then back-to-back stream (R4)
    send(128'h00112233445566778899aabbccddeeff,
         128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R3 R10 known answer set 1");
    for (int i = 0; i < 40; i++) begin
      logic [127:0] pt;
      pt = next_pt();
      send(pt, ref_enc(pt), "R4 back-to-back");
    end
    // R5 R6: zero and all-ones blocks, round 10 path (R7)
    send(128'h0, ref_enc(128'h0), "R5 zero block");
    send({128{1'b1}}, ref_enc({128{1'b1}}), "R6 all-ones block");
    send(128'h80808080808080808080808080808080,
         ref_enc(128'h80808080808080808080808080808080), "R6 R7 high bits");

    // R2: gapped stream
    for (int i = 0; i < 30; i++) begin
      logic [127:0] pt;
      pt = next_pt();
      if (i % 3 == 0) gap(1 + i % 2);
      send(pt, ref_enc(pt), "R2 gapped");
    end
    drain();

    // R8: reload a different key set, known answer
    load_keys(128'h2b7e151628aed2a6abf7158809cf4f3c);
    send(128'h3243f6a8885a308d313198a2e0370734,
         128'h3925841d02dc09fbdc118597196a0b32, "R8 R10 known answer set 2");
    for (int i = 0; i < 10; i++) begin
      logic [127:0] pt;
      pt = next_pt();
      send(pt, ref_enc(pt), "R8 reloaded keys");
    end
    drain();

    // R9: loads to unused slots must not disturb any key
    write_key(11, 128'hdeadbeefdeadbeefdeadbeefdeadbeef);
    write_key(15, 128'hffffffffffffffffffffffffffffffff);
    write_key(13, 128'h0);
    send(128'h3243f6a8885a308d313198a2e0370734,
         128'h3925841d02dc09fbdc118597196a0b32, "R9 unused slot ignored");
    for (int i = 0; i < 6; i++) begin
      logic [127:0] pt;
      pt = next_pt();
      send(pt, ref_enc(pt), "R9 unused slot ignored");
    end
    drain();

    // R1: reset in mid-stream flushes in-flight blocks
    for (int i = 0; i < 8; i++) begin
      logic [127:0] pt;
      pt = next_pt();
      send(pt, ref_enc(pt), "R1 pre-reset");
    end
    mon_on   = 1'b0;
    in_valid = 1'b0;
    rst_n    = 1'b0;
    q.delete();
    repeat (2) @(negedge clk);
    rst_n    = 1'b1;
    idle_tag = "R1";
    mon_on   = 1'b1;
    repeat (25) @(negedge clk);
    idle_tag = "R2";

    // R1: keys survive reset
    send(128'h3243f6a8885a308d313198a2e0370734,
         128'h3925841d02dc09fbdc118597196a0b32, "R1 keys kept through reset");
    drain();

    finish_test();
  end

endmodule